// File: doc/BRIEF.md
# Watchdog Timer with Register Interface

This block is a watchdog timer that software controls through a simple register bus. The input clock feeds a prescaler that gives one tick every programmed number of clocks, for example one millisecond. A tick counter advances on each tick. When it reaches the programmed 16-bit timeout, the block declares an expiry and, if allowed, drives a system reset pulse of fixed width.

Software keeps the system alive by writing any value to the restart register before the count runs out. One control word holds the prescaler divisor, two clock gates, the enable, the permission for an expiry to reset, and a force bit that starts a reset at once. Reads return the stored settings and the live tick count. Read data appears one clock after the read strobe.

Top module: `wdog_timer`

## Requirements
- R1: After reset, the control register reads 0, the timeout register reads 0x0000FFFF, the restart register reads 0, and `sys_rst_o` is low.
- R2: Offsets and readback:
  - Offset 0x0 is the control register. Its fields are divisor [17:0], enable bit 18, reset-permit bit 21, clock gate bit 24, prescaler gate bit 25, and force bit 26. Bit 26 always reads 0, and so does every other unused bit.
  - Offset 0x8 is the timeout register. It keeps only bits [15:0].
  - Offset 0xC reads the current tick count, zero-extended.
  - Any other offset reads 0.
  - `rd_data` is valid in the cycle after `rd_en`.
- R3: The prescaler and counter run only while enable, clock gate and prescaler gate are all set. Let D = max(divisor,1) and T = max(timeout,1). If the count starts from zero on a write clock edge, `sys_rst_o` is first seen high exactly T×D cycles after that edge. A divisor of 0 therefore behaves as 1, and a timeout of 0 behaves as 1.
- R4: One reset cause with no other cause following holds `sys_rst_o` high for exactly PULSE_LEN cycles (16 by default).
- R5: An expiry clears the count and leaves the enable bit set, so the next expiry comes T×D cycles after the previous one.
- R6: Clearing the enable bit freezes the tick count, and no reset occurs.
- R7: With either gate bit clear, the count stays 0 and no reset occurs.
- R8: With the reset-permit bit clear, an expiry does not raise `sys_rst_o`.
- R9: A control write with bit 26 set raises `sys_rst_o` on the next cycle, whatever the enable, the permit bit and the count are.
- R10: A write of any data to offset 0xC clears the count and the prescaler phase.
- R11: A write to the timeout register also clears the count and the prescaler phase.
- R12: A new reset cause while the pulse is high restarts the full PULSE_LEN width.
- R13: The largest timeout, 65535, expires exactly 65535×D cycles after the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Byte offset of the register |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data, registered |
| sys_rst_o | output | 1 | System reset pulse, registered |

## Verification
The bench keeps the default parameters: an 18-bit divisor, a 16-bit timeout and a 16-cycle pulse. It programs small divisors and timeouts through the registers. It sweeps every divisor from 0 to 4 against every timeout from 0 to 4 and compares each expiry delay with T×D. This covers both zero-means-one rules and the case where the pulse is still high when the next expiry retriggers it. A single run at the 65535 timeout with a divisor of 1 stays inside the cycle budget and checks the top of the count range exactly.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  // byte offsets of the registers
  localparam logic [3:0] OFS_CTRL    = 4'h0;
  localparam logic [3:0] OFS_TIMEOUT = 4'h8;
  localparam logic [3:0] OFS_KICK    = 4'hC;

  // control word field positions (software decodes these)
  localparam int BIT_ENABLE  = 18;
  localparam int BIT_RSTPERM = 21;
  localparam int BIT_CLKGATE = 24;
  localparam int BIT_PREGATE = 25;
  localparam int BIT_FORCE   = 26;

  typedef struct packed {
    logic enable;
    logic rst_perm;
    logic clk_gate;
    logic pre_gate;
  } ctrl_flags_t;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int DIV_W  = 18,
  parameter int TMO_W  = 16,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [TMO_W-1:0]  cnt_i,
  output logic [DIV_W-1:0]  div_o,
  output ctrl_flags_t       flags_o,
  output logic [TMO_W-1:0]  tmo_o,
  output logic              clr_o,
  output logic              force_o,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DIV_W-1:0]  div_q;
  ctrl_flags_t       flags_q;
  logic [TMO_W-1:0]  tmo_q;
  logic [DATA_W-1:0] rd_q;
  logic              wr_ctrl, wr_tmo, wr_kick;
  logic [DATA_W-1:0] ctrl_view;
  logic              unused_wr_bits;

  assign wr_ctrl = wr_en && (addr == ADDR_W'(OFS_CTRL));
  assign wr_tmo  = wr_en && (addr == ADDR_W'(OFS_TIMEOUT));
  assign wr_kick = wr_en && (addr == ADDR_W'(OFS_KICK));

  assign unused_wr_bits = ^wr_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q   <= '0;
      flags_q <= '0;
      tmo_q   <= '1;
    end else begin
      if (wr_ctrl) begin
        div_q            <= wr_data[DIV_W-1:0];
        flags_q.enable   <= wr_data[BIT_ENABLE];
        flags_q.rst_perm <= wr_data[BIT_RSTPERM];
        flags_q.clk_gate <= wr_data[BIT_CLKGATE];
        flags_q.pre_gate <= wr_data[BIT_PREGATE];
      end
      if (wr_tmo) tmo_q <= wr_data[TMO_W-1:0];
    end
  end

  always_comb begin
    ctrl_view              = '0;
    ctrl_view[DIV_W-1:0]   = div_q;
    ctrl_view[BIT_ENABLE]  = flags_q.enable;
    ctrl_view[BIT_RSTPERM] = flags_q.rst_perm;
    ctrl_view[BIT_CLKGATE] = flags_q.clk_gate;
    ctrl_view[BIT_PREGATE] = flags_q.pre_gate;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q <= '0;
    end else if (rd_en) begin
      case (addr)
        ADDR_W'(OFS_CTRL):    rd_q <= ctrl_view;
        ADDR_W'(OFS_TIMEOUT): rd_q <= DATA_W'(tmo_q);
        ADDR_W'(OFS_KICK):    rd_q <= DATA_W'(cnt_i);
        default:              rd_q <= '0;
      endcase
    end
  end

  assign div_o     = div_q;
  assign flags_o   = flags_q;
  assign tmo_o     = tmo_q;
  assign clr_o     = wr_tmo || wr_kick;
  assign force_o   = wr_ctrl && wr_data[BIT_FORCE];
  assign rd_data_o = rd_q;

  // R2: the timeout register changes only through a write at its offset
  a_r2_tmo_write_only: assert property (@(posedge clk) disable iff (rst)
    !wr_tmo |=> $stable(tmo_q));
endmodule

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
  parameter int DIV_W = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic             clr_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] pre_q;
  logic [DIV_W-1:0] last_phase;

  // a divisor of zero acts as one
  assign last_phase = (div_i == '0) ? '0 : div_i - DIV_W'(1);
  assign tick_o     = run_i && (pre_q >= last_phase);

  always_ff @(posedge clk) begin
    if (rst || clr_i || !run_i) pre_q <= '0;
    else if (tick_o)            pre_q <= '0;
    else                        pre_q <= pre_q + DIV_W'(1);
  end

  // R3: each tick starts a fresh prescaler period
  a_r3_tick_rewinds: assert property (@(posedge clk) disable iff (rst)
    tick_o |=> (pre_q == '0));
  // R7: with the run condition low, the phase sits at zero
  a_r7_idle_phase: assert property (@(posedge clk) disable iff (rst)
    !run_i |=> (pre_q == '0));
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             clr_i,
  input  logic [TMO_W-1:0] tmo_i,
  output logic [TMO_W-1:0] cnt_o,
  output logic             expire_o
);
  localparam int SUM_W = TMO_W + 1;

  logic [TMO_W-1:0] cnt_q;
  logic [SUM_W-1:0] next_cnt;
  logic             reach;

  assign next_cnt = {1'b0, cnt_q} + SUM_W'(1);
  assign reach    = next_cnt >= {1'b0, tmo_i};
  assign expire_o = tick_i && !clr_i && reach;

  always_ff @(posedge clk) begin
    if (rst || clr_i)  cnt_q <= '0;
    else if (expire_o) cnt_q <= '0;
    else if (tick_i)   cnt_q <= next_cnt[TMO_W-1:0];
  end

  assign cnt_o = cnt_q;

  // R11: the count stays below the programmed timeout
  a_r11_cnt_below_tmo: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == '0) || (cnt_q < tmo_i));
  // R10: a restart or timeout write empties the count
  a_r10_clear: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (cnt_q == '0));
  // R6: without a tick the count holds
  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    (!tick_i && !clr_i) |=> $stable(cnt_q));
endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse #(
  parameter int PULSE_LEN = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic trig_i,
  output logic pulse_o
);
  localparam int PW = $clog2(PULSE_LEN + 1);

  logic [PW-1:0] rem_q;
  logic          pulse_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pulse_q <= 1'b0;
      rem_q   <= '0;
    end else if (trig_i) begin
      pulse_q <= 1'b1;
      rem_q   <= PW'(PULSE_LEN - 1);
    end else if (rem_q != '0) begin
      rem_q   <= rem_q - PW'(1);
    end else begin
      pulse_q <= 1'b0;
    end
  end

  assign pulse_o = pulse_q;

  // R9: every rising edge of the reset output has a cause one cycle back
  a_r9_rise_has_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(pulse_q) |-> $past(trig_i));
  // R4: the output drops only after the width has run out
  a_r4_no_early_drop: assert property (@(posedge clk) disable iff (rst)
    $fell(pulse_q) |-> ($past(rem_q) == '0 && !$past(trig_i)));
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int DIV_W     = 18,
  parameter int TMO_W     = 16,
  parameter int PULSE_LEN = 16,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              sys_rst_o
);
  logic [DIV_W-1:0] div;
  ctrl_flags_t      flags;
  logic [TMO_W-1:0] tmo, cnt;
  logic             clr, force_rst, run, tick, expire, trig;

  wdog_regs #(.DIV_W(DIV_W), .TMO_W(TMO_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .cnt_i(cnt), .div_o(div), .flags_o(flags),
    .tmo_o(tmo), .clr_o(clr), .force_o(force_rst), .rd_data_o(rd_data)
  );

  assign run = flags.enable && flags.clk_gate && flags.pre_gate;

  wdog_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk(clk), .rst(rst), .run_i(run), .clr_i(clr), .div_i(div), .tick_o(tick)
  );

  wdog_counter #(.TMO_W(TMO_W)) u_cnt (
    .clk(clk), .rst(rst), .tick_i(tick), .clr_i(clr), .tmo_i(tmo),
    .cnt_o(cnt), .expire_o(expire)
  );

  assign trig = (expire && flags.rst_perm) || force_rst;

  wdog_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk(clk), .rst(rst), .trig_i(trig), .pulse_o(sys_rst_o)
  );

  // R8: without the permit bit, only a force write can raise the output
  a_r8_perm_gate: assert property (@(posedge clk) disable iff (rst)
    (!flags.rst_perm && !force_rst && !sys_rst_o) |=> !sys_rst_o);
endmodule

// File: tb/wdog_timer_test.sv
module wdog_timer_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        sys_rst_o;

  int n_checks = 0, n_fail = 0, cycles = 0, hi_cnt = 0;

  wdog_timer uut (.clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
                  .wr_data(wr_data), .rd_data(rd_data), .sys_rst_o(sys_rst_o));

  always #10 clk = ~clk;

  always @(negedge clk) begin
    cycles++;
    if (sys_rst_o) hi_cnt++;
    if (cycles > 190000) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rd_data;
  endtask

  function automatic logic [31:0] cw(input int dv, input bit en, input bit perm,
                                     input bit cg, input bit pg, input bit frc);
    logic [31:0] v;
    v = 32'(dv) & 32'h3FFFF;
    v[18] = en; v[21] = perm; v[24] = cg; v[25] = pg; v[26] = frc;
    return v;
  endfunction

  task automatic wait_rise(output int k);
    k = 0;
    while (!sys_rst_o && k < 70000) begin @(negedge clk); k++; end
  endtask

  task automatic quiet();
    wr(4'h0, 32'h0);
    repeat (20) @(negedge clk);
    hi_cnt = 0;
  endtask

  initial begin
    logic [31:0] d, c1, c2;
    int k, k2;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(sys_rst_o == 1'b0, "R1 output low", sys_rst_o, 0);
    rd(4'h0, d); check(d == 32'h0, "R1 control", d, 0);
    rd(4'h8, d); check(d == 32'h0000FFFF, "R1 timeout", d, 32'hFFFF);
    rd(4'hC, d); check(d == 32'h0, "R1 count", d, 0);

    // R2 readback and field masking
    wr(4'h8, 32'hABCD1234); rd(4'h8, d); check(d == 32'h1234, "R2 timeout mask", d, 32'h1234);
    wr(4'h0, 32'hFBFFFFFF); rd(4'h0, d); check(d == 32'h0327FFFF, "R2 control mask", d, 32'h0327FFFF);
    rd(4'h4, d); check(d == 32'h0, "R2 unmapped", d, 0);
    quiet();

    // R3 sweep divisor x timeout, includes zero-as-one
    for (int dv = 0; dv <= 4; dv++) begin
      for (int t = 0; t <= 4; t++) begin
        int dd, tt;
        dd = (dv == 0) ? 1 : dv;
        tt = (t == 0) ? 1 : t;
        wr(4'h8, 32'(t));
        wr(4'h0, cw(dv, 1, 1, 1, 1, 0));
        wait_rise(k);
        check(k == tt * dd, $sformatf("R3 delay div=%0d tmo=%0d", dv, t), k, tt * dd);
        quiet();
      end
    end

    // R4 width and R5 periodic re-expiry with enable kept
    wr(4'h8, 32'd5);
    wr(4'h0, cw(4, 1, 1, 1, 1, 0));
    wait_rise(k);
    check(k == 20, "R5 first expiry", k, 20);
    k2 = 0;
    while (sys_rst_o) begin @(negedge clk); k2++; end
    check(k2 == 16, "R4 pulse width", k2, 16);
    while (!sys_rst_o && k2 < 100) begin @(negedge clk); k2++; end
    check(k2 == 20, "R5 period", k2, 20);
    rd(4'h0, d); check(d[18] == 1'b1, "R5 enable kept", d[18], 1);
    quiet();

    // R6 disable freezes count
    wr(4'h8, 32'd1000);
    wr(4'h0, cw(1, 1, 1, 1, 1, 0));
    repeat (30) @(negedge clk);
    wr(4'h0, cw(1, 0, 1, 1, 1, 0));
    rd(4'hC, c1);
    repeat (30) @(negedge clk);
    rd(4'hC, c2);
    check(c1 != 0 && c1 == c2, "R6 count frozen", c2, c1);
    check(hi_cnt == 0, "R6 no reset", hi_cnt, 0);
    quiet();

    // R7 either gate clear
    wr(4'h8, 32'd3);
    wr(4'h0, cw(1, 1, 1, 1, 0, 0));
    repeat (40) @(negedge clk);
    rd(4'hC, d); check(d == 0 && hi_cnt == 0, "R7 prescaler gate off", d, 0);
    wr(4'h0, cw(1, 1, 1, 0, 1, 0));
    repeat (40) @(negedge clk);
    rd(4'hC, d); check(d == 0 && hi_cnt == 0, "R7 clock gate off", d, 0);
    quiet();

    // R8 permit clear
    wr(4'h8, 32'd3);
    wr(4'h0, cw(1, 1, 0, 1, 1, 0));
    repeat (40) @(negedge clk);
    check(hi_cnt == 0, "R8 no reset without permit", hi_cnt, 0);
    quiet();

    // R9 force, disabled and without permit
    wr(4'h0, cw(0, 0, 0, 0, 0, 1));
    check(sys_rst_o == 1'b1, "R9 force immediate", sys_rst_o, 1);
    repeat (25) @(negedge clk);
    check(hi_cnt == 16, "R9 force width", hi_cnt, 16);
    rd(4'h0, d); check(d == 32'h0, "R9 force bit reads 0", d, 0);
    hi_cnt = 0;

    // R12 retrigger during pulse
    wr(4'h0, cw(0, 0, 0, 0, 0, 1));
    repeat (3) @(negedge clk);
    wr(4'h0, cw(0, 0, 0, 0, 0, 1));
    repeat (30) @(negedge clk);
    check(hi_cnt == 21, "R12 retrigger width", hi_cnt, 21);
    quiet();

    // R10 kicks hold off expiry
    wr(4'h8, 32'd10);
    wr(4'h0, cw(2, 1, 1, 1, 1, 0));
    for (int i = 0; i < 10; i++) begin
      repeat (8) @(negedge clk);
      wr(4'hC, 32'(i * 32'h1357_9BDF));
    end
    check(hi_cnt == 0, "R10 kicks prevent reset", hi_cnt, 0);
    wait_rise(k);
    check(k == 20, "R10 expiry after last kick", k, 20);
    quiet();

    // R11 timeout write restarts
    wr(4'h8, 32'd50);
    wr(4'h0, cw(1, 1, 1, 1, 1, 0));
    repeat (20) @(negedge clk);
    wr(4'h8, 32'd7);
    wait_rise(k);
    check(k == 7, "R11 new timeout from zero", k, 7);
    quiet();

    // R13 largest timeout
    wr(4'h8, 32'hFFFF);
    wr(4'h0, cw(1, 1, 1, 1, 1, 0));
    wait_rise(k);
    check(k == 65535, "R13 max timeout", k, 65535);
    quiet();

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule